// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

The block produces the drive-level codes for a passive LCD panel that has four common electrodes and a parameterised number of segment electrodes (sixteen by default), driven at 1/4 duty so that each segment electrode serves four pixels. A small set of configuration registers holds the pixel bitmap, the bias scheme (1/2 or 1/3), a display-enable flag, a global panel-off flag and per-pin segment enables. An external timebase tick paces the frame sequencer. Every electrode gets a 2-bit code naming the supply fraction that a later analog stage should apply.

Each frame is four common phases. Each phase is split into a positive and a negative half so that every pixel sees zero net DC. In 1/3 bias a half-phase lasts `HP_TICKS` ticks; in 1/2 bias it lasts twice as long, so the 1/2 bias frame rate is half the 1/3 bias rate. After reset, or after a wake-up from clock stop (the `resume` pulse), the display-enable flag is cleared. The block then drives a waveform in which no pixel is selected until software enables the display again.

Top module: `lcdm_top`

## Requirements
- R1: `map_data` bit `c*NUM_SEG + s` is the pixel at common `c` and segment `s`. While the display is enabled, phase `c` selects common `c` only, and segment `s` shows bit `c*NUM_SEG + s`.
- R2: Level codes are 2'b00 ground, 2'b01 one third (or one half in 1/2 bias), 2'b10 two thirds, 2'b11 full supply. Common `c` is at `com_lvl[2c+1:2c]` and segment `s` is at `seg_lvl[2s+1:2s]`.
- R3: In 1/2 bias, a selected common drives 11 in the positive half and 00 in the negative half, and an unselected common drives 01. An ON segment drives the level opposite the selected common (00 positive, 11 negative). An OFF segment drives the same level as the selected common. Segments never drive 01 or 10, and commons never drive 10.
- R4: In 1/3 bias, a selected common drives 11 (positive) or 00 (negative). An unselected common drives 01 (positive) or 10 (negative). An ON segment drives 00 (positive) or 11 (negative). An OFF segment drives 10 (positive) or 01 (negative).
- R5: Half-phases run in the order phase 0 positive, phase 0 negative, phase 1 positive, and so on up to phase 3 negative, which makes eight half-phases per frame. A half-phase advances after `HP_TICKS` ticks in 1/3 bias and after `2*HP_TICKS` ticks in 1/2 bias.
- R6: A bias change written mid-frame is applied only when the frame wraps from phase 3 negative to phase 0 positive.
- R7: After reset or a `resume` pulse, the display is disabled and the sequencer restarts at phase 0 positive. All commons and segments then drive the unselected and OFF levels until `cfg_disp_on` is written as 1.
- R8: When the panel-off flag is 1, every pin enable is 0. When it is 0, all common enables and the first `GROUP_SEGS` segment enables are 1 together, and segment `GROUP_SEGS+i` follows `cfg_seg_sel[i]`. The panel-off flag is 1 after reset.
- R9: Without a tick the sequencer holds its phase, half and tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| resume | input | 1 | Wake-from-clock-stop pulse; restarts the sequence and blanks the display |
| cfg_we | input | 1 | Writes the control fields below |
| cfg_bias_third | input | 1 | 1 selects 1/3 bias, 0 selects 1/2 bias |
| cfg_disp_on | input | 1 | Display-enable value |
| cfg_lcd_off | input | 1 | Panel-off value |
| cfg_seg_sel | input | NUM_SEG-GROUP_SEGS | Individual enables for the upper segment pins |
| map_we | input | 1 | Writes the pixel bitmap |
| map_data | input | 4*NUM_SEG | Pixel bitmap |
| com_lvl | output | 8 | Level codes of the four commons |
| seg_lvl | output | 2*NUM_SEG | Level codes of the segments |
| com_pin_en | output | 4 | LCD function enables of the common pins |
| seg_pin_en | output | NUM_SEG | LCD function enables of the segment pins |

## Verification
The bench builds the block with `NUM_SEG=8`, `GROUP_SEGS=2` and `HP_TICKS=2`. With these values a 1/2 bias frame is 32 ticks and a 1/3 bias frame is 16. Full frames in both bias schemes can therefore be compared tick by tick, and so can a bias change written mid-frame and held off until the wrap. The narrow segment count still leaves six individually enabled segment pins next to the grouped ones, so the split enable rule is exercised on both sides.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

    localparam int NUM_COM = 4;
    localparam int COM_W   = 2;
    localparam int HALF_W  = 3;

    typedef enum logic [1:0] {
        LV_GND  = 2'b00,
        LV_LO   = 2'b01,
        LV_HI   = 2'b10,
        LV_FULL = 2'b11
    } lvl_e;

    typedef enum logic {
        BIAS_HALF  = 1'b0,
        BIAS_THIRD = 1'b1
    } bias_e;

    typedef struct packed {
        logic [COM_W-1:0] phase;
        logic             pol;
        bias_e            bias;
    } seq_s;

    typedef struct packed {
        bias_e bias_req;
        logic  disp_en;
        logic  lcd_off;
    } ctl_s;

    // Common electrode level: extreme when selected, middle otherwise.
    function automatic lvl_e com_code(input logic sel, input logic pol, input bias_e bias);
        lvl_e r;
        if (sel)
            r = pol ? LV_GND : LV_FULL;
        else if (bias == BIAS_THIRD)
            r = pol ? LV_HI : LV_LO;
        else
            r = LV_LO;
        return r;
    endfunction

    // Segment electrode level: ON opposes the selected common.
    function automatic lvl_e seg_code(input logic on, input logic pol, input bias_e bias);
        lvl_e r;
        if (on)
            r = pol ? LV_FULL : LV_GND;
        else if (bias == BIAS_THIRD)
            r = pol ? LV_LO : LV_HI;
        else
            r = pol ? LV_GND : LV_FULL;
        return r;
    endfunction

endpackage

// File: rtl/lcdm_seq.sv
module lcdm_seq
    import lcdm_pkg::*;
#(
    parameter int HP_TICKS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  tick,
    input  bias_e bias_req,
    output seq_s  seq
);

    localparam int LEN_MAX = 2 * HP_TICKS;
    localparam int CNT_W   = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;
    localparam logic [CNT_W-1:0] LAST_THIRD = CNT_W'(HP_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_HALF  = CNT_W'(LEN_MAX - 1);
    localparam logic [HALF_W-1:0] LAST_SLOT = '1;

    logic [CNT_W-1:0]  cnt;
    logic [HALF_W-1:0] slot;
    bias_e             bias_act;
    logic              slot_done;

    assign slot_done = (cnt == ((bias_act == BIAS_THIRD) ? LAST_THIRD : LAST_HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            slot     <= '0;
            bias_act <= BIAS_HALF;
        end else if (restart) begin
            cnt      <= '0;
            slot     <= '0;
            bias_act <= bias_req;
        end else if (tick) begin
            if (slot_done) begin
                cnt <= '0;
                if (slot == LAST_SLOT) begin
                    slot     <= '0;
                    bias_act <= bias_req;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign seq.phase = slot[HALF_W-1:1];
    assign seq.pol   = slot[0];
    assign seq.bias  = bias_act;

endmodule

// File: rtl/lcdm_cfg.sv
module lcdm_cfg
    import lcdm_pkg::*;
#(
    parameter int NUM_SEG    = 16,
    parameter int GROUP_SEGS = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               resume,
    input  logic                               cfg_we,
    input  logic                               cfg_bias_third,
    input  logic                               cfg_disp_on,
    input  logic                               cfg_lcd_off,
    input  logic [NUM_SEG-GROUP_SEGS-1:0]      cfg_seg_sel,
    input  logic                               map_we,
    input  logic [NUM_COM*NUM_SEG-1:0]         map_data,
    output ctl_s                               ctl,
    output logic [NUM_COM-1:0][NUM_SEG-1:0]    seg_map,
    output logic [NUM_COM-1:0]                 com_pin_en,
    output logic [NUM_SEG-1:0]                 seg_pin_en
);

    localparam int INDIV = NUM_SEG - GROUP_SEGS;

    logic [INDIV-1:0] seg_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.bias_req <= BIAS_HALF;
            ctl.disp_en  <= 1'b0;
            ctl.lcd_off  <= 1'b1;
            seg_sel      <= '0;
        end else if (resume) begin
            ctl.disp_en  <= 1'b0;
        end else if (cfg_we) begin
            ctl.bias_req <= cfg_bias_third ? BIAS_THIRD : BIAS_HALF;
            ctl.disp_en  <= cfg_disp_on;
            ctl.lcd_off  <= cfg_lcd_off;
            seg_sel      <= cfg_seg_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seg_map <= '0;
        else if (map_we)
            seg_map <= map_data;
    end

    assign com_pin_en = {NUM_COM{~ctl.lcd_off}};

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_pin
        if (s < GROUP_SEGS) begin : g_grp
            assign seg_pin_en[s] = ~ctl.lcd_off;
        end else begin : g_ind
            assign seg_pin_en[s] = ~ctl.lcd_off & seg_sel[s-GROUP_SEGS];
        end
    end

endmodule

// File: rtl/lcdm_levels.sv
module lcdm_levels
    import lcdm_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  seq_s                            seq,
    input  logic                            disp_en,
    input  logic [NUM_COM-1:0][NUM_SEG-1:0] seg_map,
    output logic [2*NUM_COM-1:0]            com_lvl,
    output logic [2*NUM_SEG-1:0]            seg_lvl
);

    logic [NUM_SEG-1:0] row;

    assign row = seg_map[seq.phase];

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_lvl[2*c +: 2] =
            com_code(disp_en && (seq.phase == COM_W'(c)), seq.pol, seq.bias);
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign seg_lvl[2*s +: 2] = seg_code(disp_en && row[s], seq.pol, seq.bias);
    end

endmodule

// File: rtl/lcdm_top.sv
module lcdm_top
    import lcdm_pkg::*;
#(
    parameter int NUM_SEG    = 16,
    parameter int GROUP_SEGS = 4,
    parameter int HP_TICKS   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          resume,
    input  logic                          cfg_we,
    input  logic                          cfg_bias_third,
    input  logic                          cfg_disp_on,
    input  logic                          cfg_lcd_off,
    input  logic [NUM_SEG-GROUP_SEGS-1:0] cfg_seg_sel,
    input  logic                          map_we,
    input  logic [4*NUM_SEG-1:0]          map_data,
    output logic [7:0]                    com_lvl,
    output logic [2*NUM_SEG-1:0]          seg_lvl,
    output logic [3:0]                    com_pin_en,
    output logic [NUM_SEG-1:0]            seg_pin_en
);

    ctl_s                            ctl;
    seq_s                            seq_st;
    logic [NUM_COM-1:0][NUM_SEG-1:0] seg_map;

    lcdm_cfg #(
        .NUM_SEG    (NUM_SEG),
        .GROUP_SEGS (GROUP_SEGS)
    ) u_cfg (
        .clk            (clk),
        .rst            (rst),
        .resume         (resume),
        .cfg_we         (cfg_we),
        .cfg_bias_third (cfg_bias_third),
        .cfg_disp_on    (cfg_disp_on),
        .cfg_lcd_off    (cfg_lcd_off),
        .cfg_seg_sel    (cfg_seg_sel),
        .map_we         (map_we),
        .map_data       (map_data),
        .ctl            (ctl),
        .seg_map        (seg_map),
        .com_pin_en     (com_pin_en),
        .seg_pin_en     (seg_pin_en)
    );

    lcdm_seq #(
        .HP_TICKS (HP_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (resume),
        .tick     (tick),
        .bias_req (ctl.bias_req),
        .seq      (seq_st)
    );

    lcdm_levels #(
        .NUM_SEG (NUM_SEG)
    ) u_lvl (
        .seq     (seq_st),
        .disp_en (ctl.disp_en),
        .seg_map (seg_map),
        .com_lvl (com_lvl),
        .seg_lvl (seg_lvl)
    );

endmodule

// File: rtl/lcdm_chk.sv
module lcdm_chk #(
    parameter int NUM_SEG    = 16,
    parameter int GROUP_SEGS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 resume,
    input logic                 disp_en,
    input logic                 bias_third,
    input logic [1:0]           phase,
    input logic                 pol,
    input logic [7:0]           com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [3:0]           com_pin_en,
    input logic [NUM_SEG-1:0]   seg_pin_en
);

    logic [3:0]         com_ext;
    logic [3:0]         com_hi;
    logic [3:0]         com_b0;
    logic [NUM_SEG-1:0] seg_mid;
    logic [NUM_SEG-1:0] seg_b0;

    for (genvar c = 0; c < 4; c++) begin : g_c
        assign com_ext[c] = ~(com_lvl[2*c] ^ com_lvl[2*c+1]);
        assign com_hi[c]  = com_lvl[2*c+1] & ~com_lvl[2*c];
        assign com_b0[c]  = com_lvl[2*c];
    end
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_s
        assign seg_mid[s] = seg_lvl[2*s] ^ seg_lvl[2*s+1];
        assign seg_b0[s]  = seg_lvl[2*s];
    end

    // R1: exactly the phase's common is at an extreme level when displaying
    p_select_phase_r1: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> (com_ext == (4'd1 << phase)))
        else $error("p_select_phase_r1");

    // R3: 1/2 bias never uses the 2/3 code on commons nor middle codes on segments
    p_half_levels_r3: assert property (@(posedge clk) disable iff (rst)
        !bias_third |-> (seg_mid == '0 && com_hi == '0))
        else $error("p_half_levels_r3");

    // R4: in 1/3 bias, every common and segment code sits on the polarity's side
    p_third_side_r4: assert property (@(posedge clk) disable iff (rst)
        bias_third |-> (com_b0 == {4{~pol}} && seg_b0 == {NUM_SEG{pol}}))
        else $error("p_third_side_r4");

    // R6: active bias changes only at the frame wrap
    p_bias_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(bias_third) |-> (phase == 2'd0 && !pol))
        else $error("p_bias_at_wrap_r6");

    // R7: after a resume pulse no common is selected
    p_resume_blank_r7: assert property (@(posedge clk) disable iff (rst)
        $past(resume) |-> (com_ext == '0))
        else $error("p_resume_blank_r7");

    // R8: commons and grouped segments switch together
    p_group_en_r8: assert property (@(posedge clk) disable iff (rst)
        (com_pin_en == {4{com_pin_en[0]}}) &&
        (seg_pin_en[GROUP_SEGS-1:0] == {GROUP_SEGS{com_pin_en[0]}}))
        else $error("p_group_en_r8");

    // R8: no individual segment is enabled while the panel is off
    p_off_all_r8: assert property (@(posedge clk) disable iff (rst)
        !com_pin_en[0] |-> (seg_pin_en == '0))
        else $error("p_off_all_r8");

endmodule

bind lcdm_top lcdm_chk #(
    .NUM_SEG    (NUM_SEG),
    .GROUP_SEGS (GROUP_SEGS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .resume     (resume),
    .disp_en    (ctl.disp_en),
    .bias_third (seq_st.bias == BIAS_THIRD),
    .phase      (seq_st.phase),
    .pol        (seq_st.pol),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl),
    .com_pin_en (com_pin_en),
    .seg_pin_en (seg_pin_en)
);

// File: tb/lcdm_top_tb.sv
`timescale 1ns/100ps
module lcdm_top_tb;

    localparam int NSEG = 8;
    localparam int GRP  = 2;
    localparam int HP   = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                tick = 1'b0;
    logic                resume = 1'b0;
    logic                cfg_we = 1'b0;
    logic                cfg_bias_third = 1'b0;
    logic                cfg_disp_on = 1'b0;
    logic                cfg_lcd_off = 1'b1;
    logic [NSEG-GRP-1:0] cfg_seg_sel = '0;
    logic                map_we = 1'b0;
    logic [4*NSEG-1:0]   map_data = '0;
    logic [7:0]          com_lvl;
    logic [2*NSEG-1:0]   seg_lvl;
    logic [3:0]          com_pin_en;
    logic [NSEG-1:0]     seg_pin_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the sequencing requirements (R5, R6, R7)
    int m_cnt = 0;
    int m_half = 0;
    bit m_third_act = 0;
    bit m_third_req = 0;
    bit m_disp = 0;
    logic [4*NSEG-1:0] m_map = '0;

    lcdm_top #(.NUM_SEG(NSEG), .GROUP_SEGS(GRP), .HP_TICKS(HP)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .resume(resume),
        .cfg_we(cfg_we), .cfg_bias_third(cfg_bias_third), .cfg_disp_on(cfg_disp_on),
        .cfg_lcd_off(cfg_lcd_off), .cfg_seg_sel(cfg_seg_sel),
        .map_we(map_we), .map_data(map_data),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .com_pin_en(com_pin_en), .seg_pin_en(seg_pin_en)
    );

    always #2.5 clk = ~clk;

    function automatic logic [1:0] e_com(bit sel, bit pol, bit third);
        if (sel) return pol ? 2'b00 : 2'b11;
        if (third) return pol ? 2'b10 : 2'b01;
        return 2'b01;
    endfunction

    function automatic logic [1:0] e_seg(bit on, bit pol, bit third);
        if (on) return pol ? 2'b11 : 2'b00;
        if (third) return pol ? 2'b01 : 2'b10;
        return pol ? 2'b00 : 2'b11;
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0]        ec;
        logic [2*NSEG-1:0] es;
        int ph;
        bit pl;
        ph = m_half / 2;
        pl = bit'(m_half % 2);
        for (int c = 0; c < 4; c++)
            ec[2*c +: 2] = e_com(m_disp && (ph == c), pl, m_third_act);
        for (int s = 0; s < NSEG; s++)
            es[2*s +: 2] = e_seg(m_disp && m_map[ph*NSEG + s], pl, m_third_act);
        n_checks++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_fail++;
            $display("FAIL %s: actual com=%h seg=%h expected com=%h seg=%h",
                     tag, com_lvl, seg_lvl, ec, es);
        end
    endtask

    task automatic model_step();
        int len;
        len = m_third_act ? HP : 2 * HP;
        if (m_cnt == len - 1) begin
            m_cnt = 0;
            if (m_half == 7) begin
                m_half = 0;
                m_third_act = m_third_req;
            end else begin
                m_half++;
            end
        end else begin
            m_cnt++;
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_tick();
        tick = 1'b1;
        @(posedge clk);
        model_step();
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks_checked(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            do_tick();
            check_all(tag);
        end
    endtask

    task automatic cfg_write(input bit third, input bit disp, input bit off,
                             input logic [NSEG-GRP-1:0] sel);
        cfg_we = 1'b1;
        cfg_bias_third = third;
        cfg_disp_on = disp;
        cfg_lcd_off = off;
        cfg_seg_sel = sel;
        @(posedge clk);
        m_third_req = third;
        m_disp = disp;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic map_write(input logic [4*NSEG-1:0] d);
        map_we = 1'b1;
        map_data = d;
        @(posedge clk);
        m_map = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic t_reset();
        check_all("R7 reset non-select waveform");
        check_val("R8 reset com pins off", 32'(com_pin_en), 32'h0);
        check_val("R8 reset seg pins off", 32'(seg_pin_en), 32'h0);
    endtask

    task automatic t_half_scan();
        map_write(32'hC3A5_5A3C);
        cfg_write(1'b0, 1'b1, 1'b1, '0);
        check_all("R1 R3 display on phase 0");
        ticks_checked(3, "R5 R3 first half-phase");
        // R5: 1/2 bias half-phase is 2*HP = 4 ticks; after 4 ticks com0 turns negative
        do_tick();
        check_val("R5 com0 negative after 4 ticks", 32'(com_lvl[1:0]), 32'h0);
        check_all("R3 negative half");
        ticks_checked(28, "R1 R3 R5 half bias frame");
    endtask

    task automatic t_hold();
        ticks_checked(5, "R5 pre-hold");
        repeat (6) @(negedge clk);
        check_all("R9 hold without tick");
        ticks_checked(1, "R9 resume ticking");
    endtask

    task automatic t_bias_switch();
        // finish the running frame first
        while (!(m_half == 0 && m_cnt == 0)) begin
            do_tick();
            check_all("R5 align to frame");
        end
        ticks_checked(5, "R3 before bias write");
        cfg_write(1'b1, 1'b1, 1'b1, '0);
        ticks_checked(26, "R6 bias held until wrap");
        // R6: phase 3 negative still in 1/2 bias: unselected common stays 01
        check_val("R6 no mid-frame bias change", 32'(com_lvl[3:2]), 32'h1);
        ticks_checked(1, "R6 wrap applies bias");
        map_write(32'h0F1E_2D3C);
        ticks_checked(2, "R4 third bias phase 0");
        check_val("R2 selected common negative code", 32'(com_lvl[1:0]), 32'h0);
        check_val("R2 unselected common two-thirds code", 32'(com_lvl[3:2]), 32'h2);
        ticks_checked(13, "R1 R4 third bias frame");
        ticks_checked(16, "R4 second third bias frame");
    endtask

    task automatic t_resume();
        ticks_checked(5, "R4 before resume");
        resume = 1'b1;
        @(posedge clk);
        m_cnt = 0;
        m_half = 0;
        m_third_act = m_third_req;
        m_disp = 0;
        @(negedge clk);
        resume = 1'b0;
        check_all("R7 blank after resume");
        ticks_checked(3, "R7 blank waveform runs");
        cfg_write(1'b1, 1'b1, 1'b1, '0);
        check_all("R7 display re-enabled");
    endtask

    task automatic t_pins();
        cfg_write(1'b1, 1'b1, 1'b0, 6'b101101);
        check_val("R8 com pins on", 32'(com_pin_en), 32'hF);
        check_val("R8 seg pins grouped plus selected", 32'(seg_pin_en), 32'hB7);
        check_all("R8 levels unaffected by pin enables");
        cfg_write(1'b1, 1'b1, 1'b1, 6'b111111);
        check_val("R8 panel off seg pins", 32'(seg_pin_en), 32'h0);
        check_val("R8 panel off com pins", 32'(com_pin_en), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_half_scan();
        t_hold();
        t_bias_switch();
        t_resume();
        t_pins();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule